// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block holds the per-line interrupt state of a small interrupt controller and, every clock, picks the most urgent request to offer to a processor. Each line stores a 4-bit priority and three status bits: enable, pending and active. Smaller priority numbers are more urgent. Software programs all of this through a single-word write port, one operation per cycle. A separate read port returns the stored state of any line, together with the grouping value.

A 3-bit grouping value decides how many of the upper priority bits form the pre-emption level. The remaining low bits are the subpriority. The winner is always the lowest full priority value, with the lowest line number breaking ties. This gives the same order as comparing pre-emption level first and subpriority second.

The grouping matters only for the pre-emption flag. The flag tells the processor whether the winner may interrupt the handler currently running. That handler's priority arrives on an input. The winner number, the valid flag and the pre-emption flag are registered.

Top module: `irq_grp_arbiter`

## Requirements
- R1: While reset is low, and on the first sample after it is released, every line has priority 0 and enable, pending and active all 0. The grouping value reads 0, and `win_valid`, `win_id` and `win_preempt` are 0.
- R2: A write with `wr_en` high applies `wr_op` to line `wr_line` at the clock edge. The operation codes are:
  - 0: load the priority from `wr_data`.
  - 1: set enable. 2: clear enable.
  - 3: set pending. 4: clear pending.
  - 5: set active. 6: clear active.
  - 7: load the grouping value from `wr_data[2:0]`. This operation ignores `wr_line`.

  The read port shows the new state of the line addressed by `rd_line` combinationally from that edge onward.
- R3: A line takes part in arbitration only when both its pending bit and its enable bit are 1. `win_valid` is 1 exactly when at least one line takes part.
- R4: The winner is the taking-part line with the numerically lowest 4-bit priority. Among equal priorities, the lowest line number wins. `win_id` is 0 when no line takes part.
- R5: The number of pre-emption bits equals the grouping value. The pre-emption level is the top bits of a priority, that many of them.
  - With `act_valid` low, `win_preempt` equals `win_valid`.
  - With `act_valid` high, `win_preempt` is 1 only when the winner's pre-emption level is strictly lower than that of `act_prio`. Equal levels never pre-empt.
- R6: With grouping 0 (no pre-emption bits), `win_preempt` stays 0 whenever `act_valid` is 1, whatever the priorities.
- R7: Grouping values 5, 6 and 7 behave exactly as 4, so all four priority bits form the pre-emption level.
- R8: The registered outputs follow changes one clock edge later. A write applied at edge k is reflected in the registered outputs after edge k+1. A change on `act_valid` or `act_prio` is reflected after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 3 | Write operation code (see R2) |
| wr_line | input | ID_W (3) | Line addressed by the write |
| wr_data | input | PRIO_W (4) | Priority or grouping value |
| rd_line | input | ID_W (3) | Line addressed by the read port |
| rd_prio | output | PRIO_W (4) | Priority of the read line |
| rd_enable | output | 1 | Enable bit of the read line |
| rd_pending | output | 1 | Pending bit of the read line |
| rd_active | output | 1 | Active bit of the read line |
| rd_group | output | 3 | Stored grouping value |
| act_valid | input | 1 | An interrupt handler is currently running |
| act_prio | input | PRIO_W (4) | Priority of the running handler |
| win_valid | output | 1 | A request is offered |
| win_id | output | ID_W (3) | Number of the winning line |
| win_preempt | output | 1 | The winner may pre-empt the running handler |

## Verification
The subtlest situation is a winner whose pre-emption level equals that of the running handler while its full priority is lower. In that case only the subpriority differs, and the request must not pre-empt. Reaching it needs a chosen grouping value together with priorities that differ only below the split point. Directed steps build this case, and the same priorities are then re-checked under grouping 7. Random steps then mix random groupings with random running priorities so that the equal-level boundary recurs many times.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   typedef enum logic [2:0] {
      OP_PRIO     = 3'd0,
      OP_EN_SET   = 3'd1,
      OP_EN_CLR   = 3'd2,
      OP_PEND_SET = 3'd3,
      OP_PEND_CLR = 3'd4,
      OP_ACT_SET  = 3'd5,
      OP_ACT_CLR  = 3'd6,
      OP_GROUP    = 3'd7
   } irq_op_e;

   localparam int GRP_W = 3;

   // grouping value to number of pre-emption bits, saturating at the priority width
   function automatic int unsigned pre_bits(input logic [GRP_W-1:0] grp, input int unsigned max_bits);
      int unsigned g;
      g = int'(grp);
      return (g > max_bits) ? max_bits : g;
   endfunction

endpackage

// File: rtl/irq_line_regs.sv
module irq_line_regs
   import irq_arb_pkg::*;
#(
   parameter int NUM_LINES = 8,
   parameter int PRIO_W    = 4,
   parameter int ID_W      = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [2:0]              wr_op,
   input  logic [ID_W-1:0]         wr_line,
   input  logic [PRIO_W-1:0]       wr_data,
   input  logic [ID_W-1:0]         rd_line,
   output logic [PRIO_W-1:0]       rd_prio,
   output logic                    rd_enable,
   output logic                    rd_pending,
   output logic                    rd_active,
   output logic [GRP_W-1:0]        grp_q,
   output logic [NUM_LINES-1:0]    en_vec,
   output logic [NUM_LINES-1:0]    pend_vec,
   output logic [NUM_LINES*PRIO_W-1:0] prio_flat
);

   irq_op_e op;
   assign op = irq_op_e'(wr_op);

   logic [PRIO_W-1:0] prio_arr [NUM_LINES];
   logic [NUM_LINES-1:0] act_vec;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic [PRIO_W-1:0] prio_r;
      logic en_r, pend_r, act_r;
      logic hit;
      assign hit = wr_en && (wr_line == ID_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prio_r <= '0;
            en_r   <= 1'b0;
            pend_r <= 1'b0;
            act_r  <= 1'b0;
         end else if (hit) begin
            case (op)
               OP_PRIO:     prio_r <= wr_data;
               OP_EN_SET:   en_r   <= 1'b1;
               OP_EN_CLR:   en_r   <= 1'b0;
               OP_PEND_SET: pend_r <= 1'b1;
               OP_PEND_CLR: pend_r <= 1'b0;
               OP_ACT_SET:  act_r  <= 1'b1;
               OP_ACT_CLR:  act_r  <= 1'b0;
               default: ;
            endcase
         end
      end

      assign prio_arr[i]                 = prio_r;
      assign prio_flat[i*PRIO_W +: PRIO_W] = prio_r;
      assign en_vec[i]                   = en_r;
      assign pend_vec[i]                 = pend_r;
      assign act_vec[i]                  = act_r;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         grp_q <= '0;
      else if (wr_en && op == OP_GROUP)
         grp_q <= wr_data[GRP_W-1:0];
   end

   always_comb begin
      rd_prio    = '0;
      rd_enable  = 1'b0;
      rd_pending = 1'b0;
      rd_active  = 1'b0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (rd_line == ID_W'(i)) begin
            rd_prio    = prio_arr[i];
            rd_enable  = en_vec[i];
            rd_pending = pend_vec[i];
            rd_active  = act_vec[i];
         end
      end
   end

   // R2: a pending clear leaves the addressed line not pending
   a_r2_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == 3'd4) |=> !pend_vec[$past(wr_line)]);

   // R2: an enable set leaves the addressed line enabled
   a_r2_en_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == 3'd1) |=> en_vec[$past(wr_line)]);

endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree #(
   parameter int NUM_LINES = 8,
   parameter int PRIO_W    = 4,
   parameter int ID_W      = 3
) (
   input  logic [NUM_LINES-1:0]        elig,
   input  logic [NUM_LINES*PRIO_W-1:0] prio_flat,
   output logic                        root_v,
   output logic [PRIO_W-1:0]           root_p,
   output logic [ID_W-1:0]             root_i
);

   localparam int LEAVES = 1 << ID_W;

   for (genvar L = 0; L <= ID_W; L++) begin : g_lvl
      localparam int W = LEAVES >> L;
      logic [W-1:0]      v;
      logic [PRIO_W-1:0] p  [W];
      logic [ID_W-1:0]   id [W];

      if (L == 0) begin : g_leaf
         for (genvar k = 0; k < W; k++) begin : g_k
            if (k < NUM_LINES) begin : g_real
               assign v[k]  = elig[k];
               assign p[k]  = prio_flat[k*PRIO_W +: PRIO_W];
               assign id[k] = ID_W'(k);
            end else begin : g_pad
               assign v[k]  = 1'b0;
               assign p[k]  = '1;
               assign id[k] = '0;
            end
         end
      end else begin : g_merge
         for (genvar k = 0; k < W; k++) begin : g_k
            logic take_left;
            // left child holds lower line numbers, so it wins equal priorities
            assign take_left = g_lvl[L-1].v[2*k] &&
                               (!g_lvl[L-1].v[2*k+1] ||
                                (g_lvl[L-1].p[2*k] <= g_lvl[L-1].p[2*k+1]));
            assign v[k]  = g_lvl[L-1].v[2*k] | g_lvl[L-1].v[2*k+1];
            assign p[k]  = take_left ? g_lvl[L-1].p[2*k]  : g_lvl[L-1].p[2*k+1];
            assign id[k] = take_left ? g_lvl[L-1].id[2*k] : g_lvl[L-1].id[2*k+1];
         end
      end
   end

   assign root_v = g_lvl[ID_W].v[0];
   assign root_p = g_lvl[ID_W].p[0];
   assign root_i = root_v ? g_lvl[ID_W].id[0] : '0;

   // R3 / R4: the root agrees with a flat scan of the eligible lines
   always_comb begin
      a_r3_root_valid: assert (root_v == (|elig));
      for (int i = 0; i < NUM_LINES; i++) begin
         if (elig[i]) begin
            a_r4_no_better_line: assert (root_p < prio_flat[i*PRIO_W +: PRIO_W] ||
               (root_p == prio_flat[i*PRIO_W +: PRIO_W] && int'(root_i) <= i));
         end
      end
   end

endmodule

// File: rtl/irq_preempt_check.sv
module irq_preempt_check
   import irq_arb_pkg::*;
#(
   parameter int PRIO_W = 4
) (
   input  logic [GRP_W-1:0]  grp,
   input  logic              cand_v,
   input  logic [PRIO_W-1:0] cand_p,
   input  logic              act_valid,
   input  logic [PRIO_W-1:0] act_prio,
   output logic              may_preempt
);

   int unsigned       nbits;
   logic [PRIO_W-1:0] pre_mask;

   always_comb begin
      nbits       = pre_bits(grp, PRIO_W);
      pre_mask    = ~({PRIO_W{1'b1}} >> nbits);
      may_preempt = cand_v &&
                    (!act_valid || ((cand_p & pre_mask) < (act_prio & pre_mask)));
   end

   // R6: with no pre-emption bits a running handler is never pre-empted
   always_comb begin
      if (nbits == 0 && act_valid)
         a_r6_zero_bits: assert (!may_preempt);
   end

endmodule

// File: rtl/irq_grp_arbiter.sv
module irq_grp_arbiter
   import irq_arb_pkg::*;
#(
   parameter  int NUM_LINES = 8,
   parameter  int PRIO_W    = 4,
   localparam int ID_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_op,
   input  logic [ID_W-1:0]   wr_line,
   input  logic [PRIO_W-1:0] wr_data,
   input  logic [ID_W-1:0]   rd_line,
   output logic [PRIO_W-1:0] rd_prio,
   output logic              rd_enable,
   output logic              rd_pending,
   output logic              rd_active,
   output logic [2:0]        rd_group,
   input  logic              act_valid,
   input  logic [PRIO_W-1:0] act_prio,
   output logic              win_valid,
   output logic [ID_W-1:0]   win_id,
   output logic              win_preempt
);

   if (NUM_LINES < 2) begin : g_chk_lines
      $error("irq_grp_arbiter: NUM_LINES must be at least 2");
   end
   if (PRIO_W < GRP_W || PRIO_W > 7) begin : g_chk_prio
      $error("irq_grp_arbiter: PRIO_W must lie in 3..7");
   end

   logic [GRP_W-1:0]            grp_q;
   logic [NUM_LINES-1:0]        en_vec, pend_vec;
   logic [NUM_LINES*PRIO_W-1:0] prio_flat;
   logic                        root_v;
   logic [PRIO_W-1:0]           root_p;
   logic [ID_W-1:0]             root_i;
   logic                        may_pre;

   irq_line_regs #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_op(wr_op), .wr_line(wr_line), .wr_data(wr_data),
      .rd_line(rd_line), .rd_prio(rd_prio), .rd_enable(rd_enable),
      .rd_pending(rd_pending), .rd_active(rd_active),
      .grp_q(grp_q), .en_vec(en_vec), .pend_vec(pend_vec), .prio_flat(prio_flat)
   );

   irq_prio_tree #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_tree (
      .elig(en_vec & pend_vec), .prio_flat(prio_flat),
      .root_v(root_v), .root_p(root_p), .root_i(root_i)
   );

   irq_preempt_check #(.PRIO_W(PRIO_W)) u_pre (
      .grp(grp_q), .cand_v(root_v), .cand_p(root_p),
      .act_valid(act_valid), .act_prio(act_prio), .may_preempt(may_pre)
   );

   assign rd_group = grp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_valid   <= 1'b0;
         win_id      <= '0;
         win_preempt <= 1'b0;
      end else begin
         win_valid   <= root_v;
         win_id      <= root_i;
         win_preempt <= may_pre;
      end
   end

   // R5: the pre-emption flag is only raised together with a valid winner
   a_r5_preempt_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      win_preempt |-> win_valid);

   // R6: grouping 0 with a running handler gives no pre-emption one edge later
   a_r6_group0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_q == 3'd0 && act_valid) |=> !win_preempt);

   // R3: the offered line was enabled and pending in the cycle it was chosen
   a_r3_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_valid) |-> $past(|(en_vec & pend_vec)));

endmodule

// File: tb/irq_grp_arbiter_test.sv
module irq_grp_arbiter_test;

   localparam int CLK_PERIOD = 10;
   localparam int N  = 8;
   localparam int PW = 4;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_op = '0;
   logic [IW-1:0] wr_line = '0;
   logic [PW-1:0] wr_data = '0;
   logic [IW-1:0] rd_line = '0;
   logic [PW-1:0] rd_prio;
   logic          rd_enable, rd_pending, rd_active;
   logic [2:0]    rd_group;
   logic          act_valid = 1'b0;
   logic [PW-1:0] act_prio = '0;
   logic          win_valid;
   logic [IW-1:0] win_id;
   logic          win_preempt;

   irq_grp_arbiter #(.NUM_LINES(N), .PRIO_W(PW)) uut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_op(wr_op), .wr_line(wr_line), .wr_data(wr_data),
      .rd_line(rd_line), .rd_prio(rd_prio), .rd_enable(rd_enable),
      .rd_pending(rd_pending), .rd_active(rd_active), .rd_group(rd_group),
      .act_valid(act_valid), .act_prio(act_prio),
      .win_valid(win_valid), .win_id(win_id), .win_preempt(win_preempt)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   int m_prio [N];
   bit m_en [N];
   bit m_pend [N];
   bit m_act [N];
   int m_grp;

   task automatic chk(input int actual, input int expected, input string tag);
      n_checks++;
      if (actual != expected) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
      end
   endtask

   function automatic bit exp_valid();
      for (int i = 0; i < N; i++)
         if (m_en[i] && m_pend[i]) return 1'b1;
      return 1'b0;
   endfunction

   function automatic int exp_id();
      int best = -1;
      for (int i = 0; i < N; i++)
         if (m_en[i] && m_pend[i] && (best < 0 || m_prio[i] < m_prio[best]))
            best = i;
      return (best < 0) ? 0 : best;
   endfunction

   function automatic bit exp_pre(input bit av, input int ap);
      int pb, sh;
      if (!exp_valid()) return 1'b0;
      if (!av) return 1'b1;
      pb = (m_grp > 4) ? 4 : m_grp;
      if (pb == 0) return 1'b0;
      sh = 4 - pb;
      return ((m_prio[exp_id()] >> sh) < (ap >> sh));
   endfunction

   task automatic model_apply(input int op, input int line, input int data);
      case (op)
         0: m_prio[line] = data;
         1: m_en[line]   = 1;
         2: m_en[line]   = 0;
         3: m_pend[line] = 1;
         4: m_pend[line] = 0;
         5: m_act[line]  = 1;
         6: m_act[line]  = 0;
         default: m_grp  = data & 7;
      endcase
   endtask

   // drive at a falling edge, commit on the next rising edge, then wait one more rising edge
   task automatic step(input int op, input int line, input int data, input bit av, input int ap);
      @(negedge clk);
      wr_en = 1'b1; wr_op = 3'(op); wr_line = IW'(line); wr_data = PW'(data);
      act_valid = av; act_prio = PW'(ap);
      rd_line = IW'(line);
      @(negedge clk);
      wr_en = 1'b0;
      model_apply(op, line, data);
      #1;
      chk(int'(rd_prio),    m_prio[line], "R2 rd_prio");
      chk(int'(rd_enable),  m_en[line],   "R2 rd_enable");
      chk(int'(rd_pending), m_pend[line], "R2 rd_pending");
      chk(int'(rd_active),  m_act[line],  "R2 rd_active");
      chk(int'(rd_group),   m_grp,        "R2 rd_group");
      @(negedge clk);
      #1;
      chk(int'(win_valid),   exp_valid(),        "R3 win_valid (R8 timing)");
      chk(int'(win_id),      exp_id(),           "R4 win_id");
      chk(int'(win_preempt), exp_pre(av, ap),    "R5 win_preempt");
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         m_prio[i] = 0; m_en[i] = 0; m_pend[i] = 0; m_act[i] = 0;
      end
      m_grp = 0;

      // R1: reset state
      repeat (3) @(negedge clk);
      #1;
      chk(int'(win_valid), 0, "R1 win_valid in reset");
      chk(int'(rd_group), 0, "R1 group in reset");
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(int'(win_valid), 0, "R1 win_valid");
      chk(int'(win_id), 0, "R1 win_id");
      chk(int'(win_preempt), 0, "R1 win_preempt");
      for (int i = 0; i < N; i++) begin
         rd_line = IW'(i);
         #1;
         chk(int'({rd_prio, rd_enable, rd_pending, rd_active}), 0, "R1 line state");
      end

      // R4: equal priorities go to the lower line number
      step(7, 0, 4, 0, 0);
      step(0, 5, 5, 0, 0); step(1, 5, 0, 0, 0); step(3, 5, 0, 0, 0);
      chk(int'(win_id), 5, "R4 single line 5");
      step(0, 3, 5, 0, 0); step(1, 3, 0, 0, 0); step(3, 3, 0, 0, 0);
      chk(int'(win_id), 3, "R4 tie to line 3");
      // R4: lower priority value beats lower line number
      step(0, 6, 2, 0, 0); step(1, 6, 0, 0, 0); step(3, 6, 0, 0, 0);
      chk(int'(win_id), 6, "R4 line 6 more urgent");

      // R5: equal pre-emption level never pre-empts, strictly lower does
      step(5, 6, 0, 1, 2);
      chk(int'(win_preempt), 0, "R5 equal level");
      step(6, 6, 0, 1, 3);
      chk(int'(win_preempt), 1, "R5 lower level");

      // R7: grouping 7 acts as 4 bits; grouping 2 puts 2 and 3 on one level
      step(7, 0, 7, 1, 3);
      chk(int'(win_preempt), 1, "R7 group 7 as 4 bits");
      step(7, 0, 2, 1, 3);
      chk(int'(win_preempt), 0, "R5 same level, lower subpriority");

      // R6: grouping 0 never pre-empts a running handler
      step(7, 0, 0, 1, 15);
      chk(int'(win_preempt), 0, "R6 group 0 with handler");
      step(7, 0, 0, 0, 15);
      chk(int'(win_preempt), 1, "R5 no handler running");

      // R3: a cleared enable drops the line; pending without enable is ignored
      step(2, 6, 0, 0, 0);
      chk(int'(win_id), 3, "R3 line 6 disabled");
      step(0, 0, 0, 0, 0); step(3, 0, 0, 0, 0);
      chk(int'(win_id), 3, "R3 pending but disabled line 0");
      step(4, 3, 0, 0, 0); step(4, 5, 0, 0, 0);
      chk(int'(win_valid), 0, "R3 nothing eligible");

      // random mix
      void'($urandom(32'h5eed_1234));
      for (int it = 0; it < 600; it++) begin
         int op, line, data, ap;
         bit av;
         op   = int'($urandom_range(0, 7));
         line = int'($urandom_range(0, N-1));
         data = int'($urandom_range(0, 15));
         av   = 1'($urandom_range(0, 1));
         ap   = int'($urandom_range(0, 15));
         step(op, line, data, av, ap);
      end

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule